// File: doc/BRIEF.md
# Tower-Field GF(4096) Multiplier

This block multiplies two 12-bit elements of GF(2^12). The field is a quadratic extension of GF(2^6): each operand is split into a 6-bit upper half and a 6-bit lower half. The product is assembled from GF(64) sub-products, and every sub-product is reduced modulo x^6+x+1. The extension is GF(64)[y]/(y^2+y+N), and the constant N enters through a fixed GF(64) multiply by 0x21.

A second operating mode serves as the root-stepping multiply of an error-locator search. In this mode the second operand is ignored. The result is 1 when the first operand is zero, and otherwise the first operand times the constant 0xE01. Operands enter through a valid/ready handshake. The product is held in a single output register that respects downstream backpressure.

Top module: `gf4096_tower_mul`

## Requirements
- R1: After reset, `res_valid` is 0 and `op_ready` is 1.
- R2: A GF(64) sub-product reduces modulo x^6+x+1. When both operand upper halves (bits 11:6) are zero, the result equals the reduced GF(64) product of the lower halves (bits 5:0), with the upper result half zero. Example: 0x020 times 0x002 gives 0x003.
- R3: In general mode (`root_mode`=0), the result upper half (bits 11:6) is mul(ah^al, bh^bl) ^ mul(al, bl). The lower half (bits 5:0) is mul(mul(ah, bh), 0x21) ^ mul(al, bl). Here h denotes bits 11:6 and l denotes bits 5:0 of each operand.
- R4: In general mode, multiplying by 0x001 returns the other operand unchanged, and multiplying by 0x000 returns 0x000.
- R5: In general mode, swapping the two operands gives the same result.
- R6: In root mode (`root_mode`=1), an `op_a` of 0x000 gives a result of 0x001.
- R7: In root mode with a nonzero `op_a`, the result is `op_a` times 0xE01 by the R3 rule, and `op_b` has no effect.
- R8: An operand pair is accepted on a rising edge where `op_valid` and `op_ready` are both 1. Its result appears with `res_valid`=1 in the following cycle. Results leave in the order the operand pairs were accepted.
- R9: While `res_valid` is 1 and `res_ready` is 0, `res_valid` and `result` stay unchanged and `op_ready` is 0. Otherwise `op_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Operand pair is present |
| op_ready | output | 1 | Block can take an operand pair |
| root_mode | input | 1 | 1 = root-step constant multiply, 0 = general multiply |
| op_a | input | 12 | First operand |
| op_b | input | 12 | Second operand (ignored in root mode) |
| res_valid | output | 1 | Result register holds a result |
| res_ready | input | 1 | Downstream takes the result |
| result | output | 12 | Field product |

## Verification
A wrong reduction constant or a swapped half in the tower equations shows up in the very next result word. In any multiply with nonzero halves, the value then differs from the independent tower model. A fault in the handshake state shows up differently: a result is lost or repeated, or `op_ready` disagrees with the stall condition. Either one appears in the cycle after the offending edge, because there is only one register between input and output. Operand pairs that touch only the lower halves separate reduction faults from extension faults. Random backpressure exposes holding faults.

// File: rtl/gf_tower_pkg.sv
package gf_tower_pkg;
   typedef enum logic {
      MODE_GENERAL = 1'b0,
      MODE_ROOT    = 1'b1
   } gf_mode_e;

   localparam int unsigned SUB_W_DEF  = 6;
   localparam logic [6:0]  SUB_POLY_DEF = 7'h43;
   localparam logic [5:0]  EXT_NORM_DEF = 6'h21;
   localparam logic [11:0] ROOT_K_DEF   = 12'hE01;
endpackage

// File: rtl/gf_sub_mul.sv
module gf_sub_mul #(
   parameter int unsigned   SUB_W    = gf_tower_pkg::SUB_W_DEF,
   parameter logic [SUB_W:0] SUB_POLY = gf_tower_pkg::SUB_POLY_DEF
) (
   input  logic [SUB_W-1:0] x_in,
   input  logic [SUB_W-1:0] y_in,
   output logic [SUB_W-1:0] p_out
);
   localparam logic [SUB_W-1:0] FOLD = SUB_POLY[SUB_W-1:0];

   if (SUB_W < 2) begin : g_bad_width
      $error("gf_sub_mul: SUB_W must be at least 2");
   end
   if (!SUB_POLY[SUB_W] || !SUB_POLY[0]) begin : g_bad_poly
      $error("gf_sub_mul: SUB_POLY must have degree SUB_W and a constant term");
   end

   logic [SUB_W-1:0] shifted [SUB_W+1];
   logic [SUB_W-1:0] acc     [SUB_W+1];

   assign shifted[0] = y_in;
   assign acc[0]     = '0;

   for (genvar i = 0; i < SUB_W; i++) begin : g_step
      assign acc[i+1]     = acc[i] ^ (x_in[i] ? shifted[i] : '0);
      assign shifted[i+1] = {shifted[i][SUB_W-2:0], 1'b0}
                          ^ (shifted[i][SUB_W-1] ? FOLD : '0);
   end

   assign p_out = acc[SUB_W];
endmodule

// File: rtl/gf_ext_mul.sv
module gf_ext_mul #(
   parameter int unsigned    SUB_W    = gf_tower_pkg::SUB_W_DEF,
   parameter logic [SUB_W:0] SUB_POLY = gf_tower_pkg::SUB_POLY_DEF,
   parameter logic [SUB_W-1:0] NORM   = gf_tower_pkg::EXT_NORM_DEF,
   localparam int unsigned   EXT_W    = 2 * SUB_W
) (
   input  logic [EXT_W-1:0] x_in,
   input  logic [EXT_W-1:0] y_in,
   output logic [EXT_W-1:0] p_out
);
   logic [SUB_W-1:0] xh, xl, yh, yl;
   logic [SUB_W-1:0] p_sum, p_low, p_high, p_norm;

   assign xh = x_in[EXT_W-1:SUB_W];
   assign xl = x_in[SUB_W-1:0];
   assign yh = y_in[EXT_W-1:SUB_W];
   assign yl = y_in[SUB_W-1:0];

   gf_sub_mul #(.SUB_W(SUB_W), .SUB_POLY(SUB_POLY)) u_sum (
      .x_in(xh ^ xl), .y_in(yh ^ yl), .p_out(p_sum));
   gf_sub_mul #(.SUB_W(SUB_W), .SUB_POLY(SUB_POLY)) u_low (
      .x_in(xl), .y_in(yl), .p_out(p_low));
   gf_sub_mul #(.SUB_W(SUB_W), .SUB_POLY(SUB_POLY)) u_high (
      .x_in(xh), .y_in(yh), .p_out(p_high));
   gf_sub_mul #(.SUB_W(SUB_W), .SUB_POLY(SUB_POLY)) u_norm (
      .x_in(p_high), .y_in(NORM), .p_out(p_norm));

   assign p_out = {p_sum ^ p_low, p_norm ^ p_low};
endmodule

// File: rtl/gf4096_tower_mul.sv
module gf4096_tower_mul #(
   parameter int unsigned    SUB_W    = gf_tower_pkg::SUB_W_DEF,
   parameter logic [SUB_W:0] SUB_POLY = gf_tower_pkg::SUB_POLY_DEF,
   parameter logic [SUB_W-1:0] NORM   = gf_tower_pkg::EXT_NORM_DEF,
   parameter logic [2*SUB_W-1:0] ROOT_K = gf_tower_pkg::ROOT_K_DEF
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 op_valid,
   output logic                 op_ready,
   input  logic                 root_mode,
   input  logic [2*SUB_W-1:0]   op_a,
   input  logic [2*SUB_W-1:0]   op_b,
   output logic                 res_valid,
   input  logic                 res_ready,
   output logic [2*SUB_W-1:0]   result
);
   import gf_tower_pkg::*;

   localparam int unsigned EXT_W = 2 * SUB_W;
   localparam logic [EXT_W-1:0] ONE = EXT_W'(1);

   if (ROOT_K == '0) begin : g_bad_root
      $error("gf4096_tower_mul: ROOT_K must be nonzero");
   end

   gf_mode_e         mode;
   logic [EXT_W-1:0] mul_y, mul_p, next_res;
   logic             take;

   assign mode  = gf_mode_e'(root_mode);
   assign mul_y = (mode == MODE_ROOT) ? ROOT_K : op_b;

   gf_ext_mul #(.SUB_W(SUB_W), .SUB_POLY(SUB_POLY), .NORM(NORM)) u_core (
      .x_in(op_a), .y_in(mul_y), .p_out(mul_p));

   always_comb begin
      if (mode == MODE_ROOT && op_a == '0) next_res = ONE;
      else                                 next_res = mul_p;
   end

   assign op_ready = !res_valid || res_ready;
   assign take     = op_valid && op_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid <= 1'b0;
         result    <= '0;
      end else begin
         if (take) begin
            res_valid <= 1'b1;
            result    <= next_res;
         end else if (res_ready) begin
            res_valid <= 1'b0;
         end
      end
   end

   // R8
   accept_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> res_valid);

   // R9
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && !res_ready) |=> (res_valid && $stable(result)));

   // R6
   root_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (take && root_mode && op_a == '0) |=> (result == ONE));

   // R4
   unit_operand_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (take && !root_mode && op_b == ONE) |=> (result == $past(op_a)));

   // R4
   zero_operand_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (take && !root_mode && op_a == '0) |=> (result == '0));
endmodule

// File: tb/gf4096_tower_mul_test.sv
`timescale 1ns/1ps
module gf4096_tower_mul_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_valid = 1'b0;
   logic        op_ready;
   logic        root_mode = 1'b0;
   logic [11:0] op_a = '0;
   logic [11:0] op_b = '0;
   logic        res_valid;
   logic        res_ready = 1'b1;
   logic [11:0] result;

   int tests = 0;
   int fails = 0;
   int cyc = 0;
   bit bp_on = 1'b0;
   bit run_mon = 1'b0;

   typedef struct {
      logic [11:0] exp;
      string       tag;
      int          acc_cyc;
   } item_t;
   item_t sb[$];

   gf4096_tower_mul uut (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
      .root_mode(root_mode), .op_a(op_a), .op_b(op_b),
      .res_valid(res_valid), .res_ready(res_ready), .result(result));

   always #4 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   function automatic logic [5:0] m64(logic [5:0] x, logic [5:0] y);
      logic [5:0] c = '0;
      for (int i = 0; i < 6; i++) begin
         if (x[i]) c ^= y;
         y = {y[4:0], 1'b0} ^ (y[5] ? 6'h03 : 6'h00);
      end
      return c;
   endfunction

   function automatic logic [11:0] m4096(logic [11:0] x, logic [11:0] y);
      logic [5:0] ch, cl;
      ch = m64(x[11:6] ^ x[5:0], y[11:6] ^ y[5:0]) ^ m64(x[5:0], y[5:0]);
      cl = m64(m64(x[11:6], y[11:6]), 6'h21) ^ m64(x[5:0], y[5:0]);
      return {ch, cl};
   endfunction

   task automatic check(bit ok, string tag, logic [11:0] act, logic [11:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %03h expected %03h at cycle %0d", tag, act, exp, cyc);
      end
   endtask

   task automatic send(logic [11:0] a, logic [11:0] b, bit rm,
                       logic [11:0] exp, string tag);
      item_t it;
      @(posedge clk); #1;
      op_valid = 1'b1; op_a = a; op_b = b; root_mode = rm;
      do @(negedge clk); while (!op_ready);
      it.exp = exp; it.tag = tag; it.acc_cyc = cyc;
      sb.push_back(it);
   endtask

   task automatic idle();
      @(posedge clk); #1;
      op_valid = 1'b0;
   endtask

   initial begin
      forever begin
         @(posedge clk); #1;
         res_ready = bp_on ? ($urandom_range(2) != 0) : 1'b1;
      end
   end

   // Scoreboard monitor
   bit          p_v = 1'b0, p_r = 1'b0;
   logic [11:0] p_res = '0;
   initial begin
      forever begin
         @(negedge clk);
         if (run_mon) begin
            if (p_v && !p_r)
               check(res_valid && result == p_res, "R9 hold", result, p_res);
            check(op_ready == !(res_valid && !res_ready), "R9 ready",
                  {11'd0, op_ready}, {11'd0, !(res_valid && !res_ready)});
            if (res_valid && (!p_v || p_r)) begin
               if (sb.size() == 0) begin
                  check(1'b0, "R8 unexpected result", result, 12'h000);
               end else begin
                  check(cyc == sb[0].acc_cyc + 1, "R8 latency",
                        12'(cyc), 12'(sb[0].acc_cyc + 1));
                  check(result == sb[0].exp, sb[0].tag, result, sb[0].exp);
               end
            end
            if (res_valid && res_ready && sb.size() != 0) void'(sb.pop_front());
            p_v = res_valid; p_r = res_ready; p_res = result;
         end
      end
   end

   initial begin
      #200000;
      check(1'b0, "watchdog expired", 12'h000, 12'h000);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R1
      check(res_valid == 1'b0, "R1 reset valid", {11'd0, res_valid}, 12'h000);
      check(op_ready == 1'b1, "R1 reset ready", {11'd0, op_ready}, 12'h001);
      run_mon = 1'b1;

      // R2: lower halves only
      send(12'h020, 12'h002, 0, 12'h003, "R2 x^6 fold");
      send(12'h03F, 12'h03F, 0, {6'h00, m64(6'h3F, 6'h3F)}, "R2 all ones");
      send(12'h021, 12'h010, 0, {6'h00, m64(6'h21, 6'h10)}, "R2 mixed");
      // R3: tower products
      send(12'h040, 12'h040, 0, m4096(12'h040, 12'h040), "R3 upper*upper");
      send(12'hABC, 12'h123, 0, m4096(12'hABC, 12'h123), "R3 general");
      send(12'hFFF, 12'hFFF, 0, m4096(12'hFFF, 12'hFFF), "R3 full");
      // R4
      send(12'h5A7, 12'h001, 0, 12'h5A7, "R4 times one");
      send(12'h001, 12'hC3D, 0, 12'hC3D, "R4 one times");
      send(12'h000, 12'h9E2, 0, 12'h000, "R4 zero");
      // R5
      send(12'h3C4, 12'hB19, 0, m4096(12'h3C4, 12'hB19), "R5 forward");
      send(12'hB19, 12'h3C4, 0, m4096(12'h3C4, 12'hB19), "R5 swapped");
      // R6
      send(12'h000, 12'h7FF, 1, 12'h001, "R6 root zero");
      // R7
      send(12'h001, 12'h000, 1, 12'hE01, "R7 root one");
      send(12'h2D5, 12'h000, 1, m4096(12'h2D5, 12'hE01), "R7 root b=0");
      send(12'h2D5, 12'hFFF, 1, m4096(12'h2D5, 12'hE01), "R7 root b ignored");
      idle();
      repeat (4) @(posedge clk);

      // R8/R9: random stream under backpressure
      bp_on = 1'b1;
      for (int k = 0; k < 300; k++) begin
         logic [11:0] a, b;
         bit rm;
         a = 12'($urandom); b = 12'($urandom); rm = ($urandom_range(3) == 0);
         if (k % 17 == 0) a = '0;
         if (rm) send(a, b, 1, (a == '0) ? 12'h001 : m4096(a, 12'hE01), "R7 random root");
         else    send(a, b, 0, m4096(a, b), "R3 random");
         if (k % 23 == 0) idle();
      end
      idle();
      bp_on = 1'b0;
      repeat (10) @(posedge clk);
      check(sb.size() == 0, "R8 drained", 12'(sb.size()), 12'h000);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule